// File: doc/BRIEF.md
# Flash Command Interface Controller

This block models the command side of a NOR-style flash device around a small array of registers. A host drives the chip-enable inputs, an active-low write strobe, an active-low output enable, an address bus and a 16-bit write-data bus. Bus writes are never stored in the array directly. They are decoded as commands, and some commands need more than one bus cycle. Programming can only clear bits. Erase sets every word of one block back to all ones. A two-cycle sequence loads a configuration word from the address lines.

The device drives its read data through a split output: `dq_out` carries the value and `dq_oe` marks when the pins would actually be driven. When `dq_oe` is low the bus is treated as high impedance. A read returns either an array word or the status register, depending on the read mode chosen by command. While a program or erase is in progress, every read returns the status register.

Top module: `flash_cui`

## Requirements
- R1: The device is enabled only when `ce_n` equals 3'b000. Under any other value, writes have no effect and `dq_oe` stays low.
- R2: `dq_oe` is high only while the device is enabled, `oe_n` is low and `we_n` is high. Whenever `dq_oe` is low, `dq_out` is zero.
- R3: A bus write takes effect in the clock after the write strobe (enabled and `we_n` low) ends, whether `we_n` or the chip enable ends it. It uses the address and data sampled in the last clock in which the strobe was active.
- R4: Command byte 40h (taken from data bits 7:0) arms a program. The next write replaces the addressed word with the bitwise AND of its old value and the write data.
- R5: Command byte 20h followed by confirm byte D0h erases the block that holds the confirm cycle's address. Every word of that block becomes FFFFh and other blocks are unchanged. A block is WORDS_PER_BLOCK consecutive words.
- R6: If the second byte after 20h or 60h is not the expected confirm, status bit 4 (sequence error) is set and sticks. The interface returns to idle and neither the array nor the configuration changes.
- R7: Command byte 60h followed by byte 04h loads `cfg_word` with the confirm cycle's address, keeping only bit 13 (the page-mode flag). All other bits read 0. `cfg_word` is 0 after reset.
- R8: After a program or erase takes effect, status bit 7 (ready) is 0 for BUSY_CYCLES clocks. During that time writes are ignored and reads return the status register.
- R9: After reset the read mode is array, every word is FFFFh and status is 0080h. Byte FFh selects array reads, and byte 70h selects status reads. A program or erase switches reads to status.
- R10: Command byte 50h clears the sequence-error bit.
- R11: Any other command byte in idle changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 3 | Chip-enable inputs; 3'b000 enables the device |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Word address, also carries the configuration value |
| dq_in | input | 16 | Write data / command byte in bits 7:0 |
| dq_out | output | 16 | Read data, zero when not driven |
| dq_oe | output | 1 | High when the data pins are driven |
| cfg_word | output | 16 | Configuration register |

## Verification
On every clock, the assertions check the following: a quiet bus whenever the output is not driven, status on the bus while the device is busy, the length bound of the busy count, and that programming never sets a bit. They also check that an erase leaves the block filled with ones, that the configuration changes only on its confirm cycle, and that a sequence error can rise only out of a two-cycle sequence. Other behaviour can only be shown by the bench's scenarios, which compare every cycle against a reference model. These cover write strobes ended by chip enable instead of write enable, commands ignored while busy or disabled, wrong confirm bytes, and read-mode switching.

// File: rtl/flash_cui_pkg.sv
package flash_cui_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_PROG  = 2'd1,
    SEQ_ERASE = 2'd2,
    SEQ_CFG   = 2'd3
  } seq_e;

  localparam logic [7:0] OP_PROGRAM     = 8'h40;
  localparam logic [7:0] OP_ERASE       = 8'h20;
  localparam logic [7:0] OP_ERASE_OK    = 8'hD0;
  localparam logic [7:0] OP_CFG         = 8'h60;
  localparam logic [7:0] OP_CFG_OK      = 8'h04;
  localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] OP_READ_STATUS = 8'h70;
  localparam logic [7:0] OP_CLEAR_STAT  = 8'h50;

  localparam logic [15:0] CFG_KEEP_MASK = 16'h2000;
  localparam int ST_READY_BIT = 7;
  localparam int ST_SEQERR_BIT = 4;
endpackage

// File: rtl/flash_bus_capture.sv
module flash_bus_capture #(
  parameter int ADDR_W = 16,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     din,
  output logic              enabled,
  output logic              commit,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DW-1:0]     cap_data
);
  logic strobe;
  logic strobe_q;

  assign enabled = (ce_n == 3'b000);
  assign strobe  = enabled && !we_n;
  assign commit  = strobe_q && !strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      strobe_q <= strobe;
      if (strobe) begin
        cap_addr <= addr;
        cap_data <= din;
      end
    end
  end

  a_r1_disabled_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> !strobe_q);
endmodule

// File: rtl/flash_word_array.sv
module flash_word_array #(
  parameter int DW     = 16,
  parameter int BLOCKS = 4,
  parameter int WPB    = 8,
  parameter int IW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_en,
  input  logic          erase_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  localparam int WBITS = $clog2(WPB);
  localparam int NW    = BLOCKS * WPB;

  logic [DW-1:0] all_words [NW];

  for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
    logic [DW-1:0] words [WPB];
    logic          blk_hit;
    assign blk_hit = (wr_idx[IW-1:WBITS] == b[IW-WBITS-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < WPB; w++) words[w] <= '1;
      end else if (blk_hit && erase_en) begin
        for (int w = 0; w < WPB; w++) words[w] <= '1;
      end else if (blk_hit && prog_en) begin
        words[wr_idx[WBITS-1:0]] <= words[wr_idx[WBITS-1:0]] & wr_data;
      end
    end

    for (genvar w = 0; w < WPB; w++) begin : g_word
      assign all_words[b*WPB + w] = words[w];
    end
  end

  assign rd_data = all_words[rd_idx];

  // checker state for the array assertions
  logic          chk_prog, chk_erase;
  logic [IW-1:0] chk_idx;
  logic [DW-1:0] chk_old;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_prog  <= 1'b0;
      chk_erase <= 1'b0;
      chk_idx   <= '0;
      chk_old   <= '0;
    end else begin
      chk_prog  <= prog_en;
      chk_erase <= erase_en;
      chk_idx   <= wr_idx;
      chk_old   <= all_words[wr_idx];
    end
  end

  a_r4_program_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    chk_prog |-> ((all_words[chk_idx] & ~chk_old) == '0));
  a_r5_erase_fills_ones: assert property (@(posedge clk) disable iff (!rst_n)
    chk_erase |-> (all_words[{chk_idx[IW-1:WBITS], {WBITS{1'b0}}}] == '1));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cui_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int IW          = 5,
  parameter int BUSY_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [15:0]       cap_data,
  output logic              prog_en,
  output logic              erase_en,
  output logic [IW-1:0]     wr_idx,
  output logic [15:0]       cfg_q,
  output logic [15:0]       status,
  output logic              ready,
  output logic              status_mode
);
  localparam int BCW = $clog2(BUSY_CYCLES + 1);

  seq_e           state;
  logic [BCW-1:0] busy_cnt;
  logic           seq_err;
  logic           accept;
  logic [7:0]     op;

  assign op       = cap_data[7:0];
  assign ready    = (busy_cnt == '0);
  assign accept   = commit && ready;
  assign prog_en  = accept && (state == SEQ_PROG);
  assign erase_en = accept && (state == SEQ_ERASE) && (op == OP_ERASE_OK);
  assign wr_idx   = cap_addr[IW-1:0];

  always_comb begin
    status = '0;
    status[ST_READY_BIT]  = ready;
    status[ST_SEQERR_BIT] = seq_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SEQ_IDLE;
      busy_cnt    <= '0;
      seq_err     <= 1'b0;
      cfg_q       <= '0;
      status_mode <= 1'b0;
    end else begin
      if (!ready) busy_cnt <= busy_cnt - 1'b1;
      if (accept) begin
        unique case (state)
          SEQ_IDLE: begin
            case (op)
              OP_PROGRAM:     state <= SEQ_PROG;
              OP_ERASE:       state <= SEQ_ERASE;
              OP_CFG:         state <= SEQ_CFG;
              OP_READ_ARRAY:  status_mode <= 1'b0;
              OP_READ_STATUS: status_mode <= 1'b1;
              OP_CLEAR_STAT:  seq_err <= 1'b0;
              default:        ;
            endcase
          end
          SEQ_PROG: begin
            state       <= SEQ_IDLE;
            status_mode <= 1'b1;
            busy_cnt    <= BCW'(BUSY_CYCLES);
          end
          SEQ_ERASE: begin
            state <= SEQ_IDLE;
            if (op == OP_ERASE_OK) begin
              status_mode <= 1'b1;
              busy_cnt    <= BCW'(BUSY_CYCLES);
            end else begin
              seq_err <= 1'b1;
            end
          end
          SEQ_CFG: begin
            state <= SEQ_IDLE;
            if (op == OP_CFG_OK) cfg_q <= cap_addr[15:0] & CFG_KEEP_MASK;
            else                 seq_err <= 1'b1;
          end
          default: state <= SEQ_IDLE;
        endcase
      end
    end
  end

  a_r8_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= BCW'(BUSY_CYCLES));
  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt > BCW'(1)) |=> !ready);
  a_r7_cfg_only_on_confirm: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> ($past(state) == SEQ_CFG));
  a_r6_seqerr_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_err) |-> ($past(state) == SEQ_ERASE || $past(state) == SEQ_CFG));
endmodule

// File: rtl/flash_cui.sv
module flash_cui #(
  parameter int ADDR_W          = 16,
  parameter int BLOCKS          = 4,
  parameter int WORDS_PER_BLOCK = 8,
  parameter int BUSY_CYCLES     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic              dq_oe,
  output logic [15:0]       cfg_word
);
  localparam int IW = $clog2(WORDS_PER_BLOCK) + $clog2(BLOCKS);

  logic              enabled, commit;
  logic [ADDR_W-1:0] cap_addr;
  logic [15:0]       cap_data;
  logic              prog_en, erase_en, ready, status_mode;
  logic [IW-1:0]     wr_idx;
  logic [15:0]       status, rd_word;

  flash_bus_capture #(.ADDR_W(ADDR_W), .DW(16)) u_cap (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .din(dq_in), .enabled(enabled), .commit(commit),
    .cap_addr(cap_addr), .cap_data(cap_data)
  );

  flash_cmd_seq #(.ADDR_W(ADDR_W), .IW(IW), .BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .commit(commit), .cap_addr(cap_addr),
    .cap_data(cap_data), .prog_en(prog_en), .erase_en(erase_en),
    .wr_idx(wr_idx), .cfg_q(cfg_word), .status(status), .ready(ready),
    .status_mode(status_mode)
  );

  flash_word_array #(.DW(16), .BLOCKS(BLOCKS), .WPB(WORDS_PER_BLOCK), .IW(IW)) u_arr (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .erase_en(erase_en),
    .wr_idx(wr_idx), .wr_data(cap_data), .rd_idx(addr[IW-1:0]),
    .rd_data(rd_word)
  );

  assign dq_oe = enabled && !oe_n && we_n;

  always_comb begin
    if (!dq_oe)                      dq_out = '0;
    else if (status_mode || !ready)  dq_out = status;
    else                             dq_out = rd_word;
  end

  a_r2_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0));
  a_r8_status_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && !ready) |-> (dq_out == status));
endmodule

// File: tb/flash_cui_tb_top.sv
`timescale 1ns/1ps
module flash_cui_tb_top;
  localparam int ADDR_W = 16;
  localparam int BLOCKS = 4;
  localparam int WPB    = 8;
  localparam int BUSY   = 6;
  localparam int NW     = BLOCKS * WPB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] ce_n = 3'b111;
  logic we_n = 1'b1;
  logic oe_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out, cfg_word;
  logic dq_oe;

  always #10 clk = ~clk;  // 50 MHz

  flash_cui #(.ADDR_W(ADDR_W), .BLOCKS(BLOCKS), .WORDS_PER_BLOCK(WPB),
              .BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .cfg_word(cfg_word)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference model
  logic [15:0] m_mem [NW];
  logic [15:0] m_cfg;
  int m_seq, m_busy;
  bit m_err, m_stat_mode, m_act_q;
  logic [ADDR_W-1:0] m_addr_q;
  logic [15:0] m_data_q;

  task automatic model_apply(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    int i, blk;
    i = int'(a) % NW;
    blk = i / WPB;
    case (m_seq)
      0: begin
        if (d[7:0] == 8'h40) m_seq = 1;
        else if (d[7:0] == 8'h20) m_seq = 2;
        else if (d[7:0] == 8'h60) m_seq = 3;
        else if (d[7:0] == 8'hFF) m_stat_mode = 0;
        else if (d[7:0] == 8'h70) m_stat_mode = 1;
        else if (d[7:0] == 8'h50) m_err = 0;
      end
      1: begin
        m_mem[i] = m_mem[i] & d;
        m_stat_mode = 1; m_busy = BUSY; m_seq = 0;
      end
      2: begin
        if (d[7:0] == 8'hD0) begin
          for (int j = 0; j < WPB; j++) m_mem[blk*WPB + j] = 16'hFFFF;
          m_stat_mode = 1; m_busy = BUSY;
        end else m_err = 1;
        m_seq = 0;
      end
      default: begin
        if (d[7:0] == 8'h04) m_cfg = a[15:0] & 16'h2000;
        else m_err = 1;
        m_seq = 0;
      end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NW; k++) m_mem[k] = 16'hFFFF;
      m_cfg = 0; m_seq = 0; m_busy = 0; m_err = 0; m_stat_mode = 0;
      m_act_q = 0; m_addr_q = 0; m_data_q = 0;
    end else begin
      bit act;
      int busy_before;
      act = (ce_n == 3'b000) && !we_n;
      busy_before = m_busy;
      if (m_busy > 0) m_busy--;
      if (m_act_q && !act && busy_before == 0) model_apply(m_addr_q, m_data_q);
      if (act) begin m_addr_q = addr; m_data_q = dq_in; end
      m_act_q = act;
    end
  end

  function automatic logic [15:0] model_status();
    logic [15:0] s;
    s = 16'h0;
    s[7] = (m_busy == 0);
    s[4] = m_err;
    return s;
  endfunction

  // per-cycle comparison (R3 timing, R2 gating, R9 modes)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit eoe;
      logic [15:0] edq;
      eoe = (ce_n == 3'b000) && !oe_n && we_n;
      if (!eoe) edq = 16'h0;
      else if (m_stat_mode || m_busy > 0) edq = model_status();
      else edq = m_mem[int'(addr) % NW];
      n_checks++;
      if (dq_oe !== eoe || dq_out !== edq || cfg_word !== m_cfg) begin
        n_fail++;
        $display("FAIL R3 model compare t=%0t: oe=%b dq=%h cfg=%h expected oe=%b dq=%h cfg=%h",
                 $time, dq_oe, dq_out, cfg_word, eoe, edq, m_cfg);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk); #2;
    ce_n = 3'b000; oe_n = 1'b1; addr = a; dq_in = d; we_n = 1'b0;
    @(negedge clk); #2;
    we_n = 1'b1;
  endtask

  task automatic bus_write_ce_end(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk); #2;
    ce_n = 3'b000; oe_n = 1'b1; addr = a; dq_in = d; we_n = 1'b0;
    @(negedge clk); #2;
    ce_n = 3'b111;
    @(negedge clk); #2;
    we_n = 1'b1;
    @(negedge clk); #2;
    ce_n = 3'b000;
  endtask

  task automatic read_check(input logic [ADDR_W-1:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); #2;
    ce_n = 3'b000; addr = a; oe_n = 1'b0;
    @(negedge clk);
    check(dq_oe === 1'b1 && dq_out === exp, tag, dq_out, exp);
    #2 oe_n = 1'b1;
  endtask

  task automatic wait_idle();
    repeat (BUSY + 2) @(negedge clk);
  endtask

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ce_n = 3'b000;
    @(negedge clk);
    check(cfg_word === 16'h0, "R7 cfg after reset", cfg_word, 16'h0);
    read_check(16'd0, 16'hFFFF, "R9 array mode after reset");
    bus_write(16'd0, 16'h0070);
    read_check(16'd0, 16'h0080, "R9 status after reset");
    bus_write(16'd0, 16'h00FF);

    // program and busy
    bus_write(16'd0, 16'h0040);
    bus_write(16'd0, 16'hA5A5);
    read_check(16'd0, 16'h0000, "R8 busy status");
    bus_write(16'd0, 16'h00FF);          // ignored, busy
    wait_idle();
    read_check(16'd0, 16'h0080, "R8 write ignored while busy");
    bus_write(16'd0, 16'h00FF);
    read_check(16'd0, 16'hA5A5, "R4 first program");
    bus_write(16'd0, 16'h0040);
    bus_write(16'd0, 16'h0FF0);
    wait_idle();
    bus_write(16'd0, 16'h00FF);
    read_check(16'd0, 16'h05A0, "R4 program ANDs");

    // write ended by chip enable
    bus_write(16'd9, 16'h0040);
    bus_write_ce_end(16'd9, 16'h1234);
    wait_idle();
    bus_write(16'd0, 16'h00FF);
    read_check(16'd9, 16'h1234, "R3 chip-enable ends write");

    // erase block 0 through address 3
    bus_write(16'd3, 16'h0020);
    bus_write(16'd3, 16'h00D0);
    wait_idle();
    bus_write(16'd0, 16'h00FF);
    read_check(16'd0, 16'hFFFF, "R5 erased word");
    read_check(16'd9, 16'h1234, "R5 other block kept");

    // bad confirm
    bus_write(16'd9, 16'h0020);
    bus_write(16'd9, 16'h0055);
    bus_write(16'd0, 16'h0070);
    read_check(16'd0, 16'h0090, "R6 sequence error");
    bus_write(16'd0, 16'h00FF);
    read_check(16'd9, 16'h1234, "R6 array unchanged");

    // disabled device
    @(negedge clk); #2;
    ce_n = 3'b010; dq_in = 16'h0050; we_n = 1'b0;
    @(negedge clk); #2; we_n = 1'b1;
    @(negedge clk); #2; oe_n = 1'b0;
    @(negedge clk);
    check(dq_oe === 1'b0 && dq_out === 16'h0, "R1 disabled no drive", dq_out, 16'h0);
    #2 oe_n = 1'b1; ce_n = 3'b000;
    bus_write(16'd0, 16'h0070);
    read_check(16'd0, 16'h0090, "R1 disabled write ignored");
    bus_write(16'd0, 16'h0050);
    read_check(16'd0, 16'h0080, "R10 clear status");

    // configuration
    bus_write(16'hFFFF, 16'h0060);
    bus_write(16'hFFFF, 16'h0004);
    @(negedge clk); @(negedge clk);
    check(cfg_word === 16'h2000, "R7 page flag only", cfg_word, 16'h2000);
    bus_write(16'h0000, 16'h0060);
    bus_write(16'h0000, 16'h0004);
    @(negedge clk); @(negedge clk);
    check(cfg_word === 16'h0000, "R7 flag cleared", cfg_word, 16'h0000);
    bus_write(16'hFFFF, 16'h0060);
    bus_write(16'hFFFF, 16'h0005);
    @(negedge clk); @(negedge clk);
    check(cfg_word === 16'h0000, "R7 bad confirm keeps cfg", cfg_word, 16'h0000);
    read_check(16'd0, 16'h0090, "R6 cfg bad confirm flags error");
    bus_write(16'd0, 16'h0050);

    // unknown command
    bus_write(16'd0, 16'h00FF);
    bus_write(16'd0, 16'h0033);
    read_check(16'd0, 16'hFFFF, "R11 unknown command ignored");

    // output gating
    @(negedge clk); #2; oe_n = 1'b1;
    @(negedge clk);
    check(dq_oe === 1'b0 && dq_out === 16'h0, "R2 oe_n high", dq_out, 16'h0);
    #2 oe_n = 1'b0; we_n = 1'b0; dq_in = 16'h00FF;
    @(negedge clk);
    check(dq_oe === 1'b0 && dq_out === 16'h0, "R2 write blocks drive", dq_out, 16'h0);
    #2 we_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule